// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Engine

This block carries out one memory-to-memory (or memory-to-fixed-address) copy cycle on behalf of a single channel. The cycle is described by a descriptor: a source end pointer, a destination end pointer and a 32-bit control word. The control word selects the run mode, the item width on each side, the address step on each side, the item count and how often the engine gives the channel back to the arbiter. Both pointers name the address of the final item, so the engine walks each address upward toward its end pointer as the remaining count falls.

Each time the engine wins arbitration, it fetches the descriptor that is currently selected (primary or alternate). It then moves items one at a time, reading an item and then writing it. After every item it writes an updated control word back into the descriptor. The block has three edges: an arbitration handshake, a descriptor fetch and write-back port, and a single memory port that carries one request and one response at a time. Arbitration among several channels and conversion to a system bus are handled outside the block.

Top module: `dde_engine`

## Requirements
- R1: The control word is decoded by field position: bits 31:30 destination step, 29:28 destination width, 27:26 source step, 25:24 source width, 17:14 release exponent, 13:4 item count minus one, 2:0 run mode. A width code of 00, 01 or 10 gives a 1, 2 or 4 byte item on the memory port's size output. Each item is read at the source width and written at the destination width. The write carries the low bytes of the read data.
- R2: The engine computes the address of item i of N as the end pointer minus (N-1-i) times the step. Step code 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. Step code 11 keeps the address fixed at the end pointer.
- R3: For each item, the read request comes first. The write of that item starts only after the read response. Items are moved in ascending address order.
- R4: A cycle moves exactly N items, where N is the count field plus one. N can range from 1 to 1024.
- R5: If the fetched run mode is 000, or any code from 100 to 111, the engine issues no memory beat, writes nothing back, raises no done pulse and returns to idle.
- R6: Basic mode (001): after 2^R items the engine releases the channel. It resumes only when the request input is high while the engine is idle.
- R7: Auto mode (010): one request is enough to finish the whole cycle. After each release the engine re-arbitrates by itself, so a cycle of N items uses ceil(N / 2^R) arbitrations.
- R8: Release exponents 0 to 10 give a period of 2^R items. Codes 11 to 15 all give 1024 items.
- R9: Ping-pong mode (011): the primary descriptor is used first. Each completed descriptor switches the selection to the other one, and each completion raises its own done pulse. The engine treats the request the same way as in basic mode.
- R10: After every item, the control word is written back with all other fields unchanged. While items remain, the count field holds the number of items left minus one. After the last item, the count field is 0 and the mode field is 000.
- R11: `done` is high for exactly one clock. It is raised in the clock after the final write response, in the same clock as the last write-back.
- R12: While `chan_en` is low, the request input and any pending self-request are ignored, and the engine does not ask for arbitration.
- R13: A memory request stays asserted, with its address and direction unchanged, until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; when low, no new arbitration starts |
| req | input | 1 | Channel request (level) |
| grant | input | 1 | Arbitration grant for `arb_req` |
| arb_req | output | 1 | Engine asks for the channel |
| desc_rd | output | 1 | Descriptor fetch request |
| desc_alt | output | 1 | Selected descriptor: 0 primary, 1 alternate |
| desc_vld | input | 1 | Fetched descriptor is valid this clock |
| desc_src_end | input | ADDR_W | Source end pointer |
| desc_dst_end | input | ADDR_W | Destination end pointer |
| desc_ctrl | input | 32 | Control word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Item width code |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_rsp` |
| mem_rsp | input | 1 | Response for the current request |
| wb_valid | output | 1 | Control word write-back strobe |
| wb_alt | output | 1 | Descriptor that the write-back targets |
| wb_ctrl | output | 32 | Updated control word |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench instantiates the engine with its defaults: 32-bit addresses and data, and a release cap of 10. With these values the bench can run a full 1024-item cycle and confirm that release codes 11 to 15 behave the same as code 10. It can also pick random release codes from 0 to 12, so that the number of arbitrations per cycle varies from once per item to once per cycle. The 32-bit data path lets the bench mix byte, halfword and word widths on the two sides. The byte-addressed memory model, held in the bench, then exposes any truncation or address-step error.

// File: rtl/dde_pkg.sv
package dde_pkg;

    localparam int CNT_W = 10;

    localparam logic [1:0] STEP_BYTE = 2'b00;
    localparam logic [1:0] STEP_HALF = 2'b01;
    localparam logic [1:0] STEP_WORD = 2'b10;
    localparam logic [1:0] STEP_HOLD = 2'b11;

    localparam logic [2:0] MODE_STOP     = 3'b000;
    localparam logic [2:0] MODE_BASIC    = 3'b001;
    localparam logic [2:0] MODE_AUTO     = 3'b010;
    localparam logic [2:0] MODE_PINGPONG = 3'b011;

    typedef struct packed {
        logic [1:0]       dst_step;
        logic [1:0]       dst_width;
        logic [1:0]       src_step;
        logic [1:0]       src_width;
        logic [2:0]       dst_prot;
        logic [2:0]       src_prot;
        logic [3:0]       rel_pow;
        logic [CNT_W-1:0] left_m1;
        logic             burst_hint;
        logic [2:0]       mode;
    } ctrl_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_FETCH,
        ST_READ,
        ST_WRITE
    } eng_state_e;

    function automatic logic mode_moves(input logic [2:0] m);
        return (m == MODE_BASIC) || (m == MODE_AUTO) || (m == MODE_PINGPONG);
    endfunction

endpackage

// File: rtl/dde_addr_gen.sv
module dde_addr_gen
    import dde_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [1:0]        step,
    input  logic [CNT_W-1:0]  left_m1,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFF_W = CNT_W + 2;

    logic [OFF_W-1:0] off;

    always_comb begin
        case (step)
            STEP_BYTE: off = {2'b00, left_m1};
            STEP_HALF: off = {1'b0, left_m1, 1'b0};
            STEP_WORD: off = {left_m1, 2'b00};
            default:   off = '0;
        endcase
    end

    assign addr = end_ptr - ADDR_W'(off);

endmodule

// File: rtl/dde_rearb.sv
module dde_rearb
    import dde_pkg::*;
#(
    parameter int CAP_POW = 10
) (
    input  logic [3:0]     rel_pow,
    output logic [CNT_W:0] limit
);
    localparam int LIM_W = CNT_W + 1;

    always_comb begin
        if (rel_pow > 4'(CAP_POW))
            limit = LIM_W'(1) << CAP_POW;
        else
            limit = LIM_W'(1) << rel_pow;
    end

endmodule

// File: rtl/dde_wb_fmt.sv
module dde_wb_fmt
    import dde_pkg::*;
(
    input  ctrl_word_t cur,
    input  logic       last,
    output ctrl_word_t nxt
);
    always_comb begin
        nxt = cur;
        if (last) begin
            nxt.left_m1 = '0;
            nxt.mode    = MODE_STOP;
        end else begin
            nxt.left_m1 = cur.left_m1 - CNT_W'(1);
        end
    end

endmodule

// File: rtl/dde_engine.sv
module dde_engine
    import dde_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int RPOW_CAP = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              req,
    input  logic              grant,
    output logic              arb_req,
    output logic              desc_rd,
    output logic              desc_alt,
    input  logic              desc_vld,
    input  logic [ADDR_W-1:0] desc_src_end,
    input  logic [ADDR_W-1:0] desc_dst_end,
    input  logic [31:0]       desc_ctrl,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rsp,
    output logic              wb_valid,
    output logic              wb_alt,
    output logic [31:0]       wb_ctrl,
    output logic              done
);
    localparam int LIM_W  = CNT_W + 1;
    localparam int N_SIDE = 2;

    eng_state_e        state_q;
    logic              alt_q;
    logic              pend_q;
    logic [ADDR_W-1:0] src_end_q;
    logic [ADDR_W-1:0] dst_end_q;
    ctrl_word_t        ctrl_q;
    logic [LIM_W-1:0]  beat_q;
    logic [DATA_W-1:0] data_q;
    logic              wb_valid_q;
    logic              wb_alt_q;
    ctrl_word_t        wb_q;
    logic              done_q;

    // address generation, one per side (0 source, 1 destination)
    logic [ADDR_W-1:0] side_end  [N_SIDE];
    logic [1:0]        side_step [N_SIDE];
    logic [ADDR_W-1:0] side_addr [N_SIDE];

    assign side_end[0]  = src_end_q;
    assign side_end[1]  = dst_end_q;
    assign side_step[0] = ctrl_q.src_step;
    assign side_step[1] = ctrl_q.dst_step;

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        dde_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
            .end_ptr (side_end[g]),
            .step    (side_step[g]),
            .left_m1 (ctrl_q.left_m1),
            .addr    (side_addr[g])
        );
    end

    logic [LIM_W-1:0] rel_limit;

    dde_rearb #(.CAP_POW(RPOW_CAP)) u_rearb (
        .rel_pow (ctrl_q.rel_pow),
        .limit   (rel_limit)
    );

    logic       last_item;
    ctrl_word_t ctrl_next;

    assign last_item = (ctrl_q.left_m1 == '0);

    dde_wb_fmt u_wb_fmt (
        .cur  (ctrl_q),
        .last (last_item),
        .nxt  (ctrl_next)
    );

    logic [LIM_W-1:0] beat_next;
    logic             release_now;

    assign beat_next   = beat_q + LIM_W'(1);
    assign release_now = (beat_next == rel_limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            alt_q      <= 1'b0;
            pend_q     <= 1'b0;
            src_end_q  <= '0;
            dst_end_q  <= '0;
            ctrl_q     <= '0;
            beat_q     <= '0;
            data_q     <= '0;
            wb_valid_q <= 1'b0;
            wb_alt_q   <= 1'b0;
            wb_q       <= '0;
            done_q     <= 1'b0;
        end else begin
            wb_valid_q <= 1'b0;
            done_q     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (!chan_en)
                        pend_q <= 1'b0;
                    else if (req || pend_q)
                        state_q <= ST_ARB;
                end
                ST_ARB: begin
                    if (grant)
                        state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (desc_vld) begin
                        src_end_q <= desc_src_end;
                        dst_end_q <= desc_dst_end;
                        ctrl_q    <= ctrl_word_t'(desc_ctrl);
                        beat_q    <= '0;
                        if (mode_moves(desc_ctrl[2:0])) begin
                            state_q <= ST_READ;
                        end else begin
                            state_q <= ST_IDLE;
                            pend_q  <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_rsp) begin
                        data_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_rsp) begin
                        wb_valid_q <= 1'b1;
                        wb_alt_q   <= alt_q;
                        wb_q       <= ctrl_next;
                        ctrl_q     <= ctrl_next;
                        if (last_item) begin
                            done_q  <= 1'b1;
                            pend_q  <= 1'b0;
                            state_q <= ST_IDLE;
                            if (ctrl_q.mode == MODE_PINGPONG)
                                alt_q <= ~alt_q;
                        end else begin
                            beat_q <= beat_next;
                            if (release_now) begin
                                state_q <= ST_IDLE;
                                pend_q  <= (ctrl_q.mode == MODE_AUTO);
                            end else begin
                                state_q <= ST_READ;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign arb_req   = (state_q == ST_ARB);
    assign desc_rd   = (state_q == ST_FETCH);
    assign desc_alt  = alt_q;
    assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = mem_we ? side_addr[1] : side_addr[0];
    assign mem_size  = mem_we ? ctrl_q.dst_width : ctrl_q.src_width;
    assign mem_wdata = data_q;
    assign wb_valid  = wb_valid_q;
    assign wb_alt    = wb_alt_q;
    assign wb_ctrl   = wb_q;
    assign done      = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_STOPS_DESC: assert property (@(posedge clk) disable iff (rst)
        done |-> (wb_valid && (wb_ctrl[2:0] == MODE_STOP) && (wb_ctrl[13:4] == '0))); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> ($past(mem_rsp) && $past(mem_req) && !$past(mem_we))); // R3

    AST_NO_ARB_OFF: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && !arb_req) |=> !arb_req); // R12

    AST_STOP_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        (desc_rd && desc_vld && !mode_moves(desc_ctrl[2:0])) |=> !mem_req); // R5

endmodule

// File: tb/dde_engine_bench.sv
module dde_engine_bench;
    localparam int  AW   = 32;
    localparam int  DW   = 32;
    localparam int  MSZ  = 8192;
    localparam int  WD   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chan_en = 1'b1;
    logic          req = 1'b0;
    logic          grant = 1'b0;
    logic          arb_req;
    logic          desc_rd;
    logic          desc_alt;
    logic          desc_vld = 1'b0;
    logic [AW-1:0] desc_src_end = '0;
    logic [AW-1:0] desc_dst_end = '0;
    logic [31:0]   desc_ctrl = '0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rsp = 1'b0;
    logic          wb_valid;
    logic          wb_alt;
    logic [31:0]   wb_ctrl;
    logic          done;

    always #10 clk = ~clk;

    dde_engine u_dde_engine (
        .clk(clk), .rst(rst), .chan_en(chan_en), .req(req), .grant(grant),
        .arb_req(arb_req), .desc_rd(desc_rd), .desc_alt(desc_alt), .desc_vld(desc_vld),
        .desc_src_end(desc_src_end), .desc_dst_end(desc_dst_end), .desc_ctrl(desc_ctrl),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rsp(mem_rsp),
        .wb_valid(wb_valid), .wb_alt(wb_alt), .wb_ctrl(wb_ctrl), .done(done)
    );

    logic [7:0]  mem     [MSZ];
    logic [7:0]  ref_mem [MSZ];
    logic [31:0] dsc_src [2];
    logic [31:0] dsc_dst [2];
    logic [31:0] dsc_ctl [2];

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_wr = 0, n_arb = 0, n_done = 0, lat = 0;
    logic prev_arb = 1'b0;

    function automatic int width_bytes(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
    endfunction

    function automatic int step_bytes(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 0;
    endfunction

    function automatic logic [31:0] mk_ctl(input logic [1:0] dst, input logic [1:0] dw,
                                           input logic [1:0] sst, input logic [1:0] sw,
                                           input logic [3:0] rp, input logic [9:0] nm1,
                                           input logic [2:0] mode);
        return {dst, dw, sst, sw, 3'b000, 3'b000, rp, nm1, 1'b0, mode};
    endfunction

    function automatic int arbs_for(input int n, input logic [3:0] rp);
        int l = 1 << ((rp > 4'd10) ? 10 : int'(rp));
        return (n + l - 1) / l;
    endfunction

    task automatic summary_and_end();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // single process drives every bench-side responder and monitor
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > WD) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD);
            summary_and_end();
        end
        if (done) n_done++;
        if (arb_req && !prev_arb) n_arb++;
        prev_arb = arb_req;
        if (wb_valid) dsc_ctl[wb_alt] = wb_ctrl;
        if (mem_rsp) begin
            mem_rsp = 1'b0;
        end else if (mem_req) begin
            if (lat == 0) begin
                if (mem_we) begin
                    for (int b = 0; b < width_bytes(mem_size); b++)
                        mem[(int'(mem_addr) + b) % MSZ] = mem_wdata[8*b +: 8];
                    n_wr++;
                end else begin
                    mem_rdata = '0;
                    for (int b = 0; b < width_bytes(mem_size); b++)
                        mem_rdata[8*b +: 8] = mem[(int'(mem_addr) + b) % MSZ];
                end
                mem_rsp = 1'b1;
                lat = int'($urandom % 3);
            end else begin
                lat--;
            end
        end
        if (desc_vld) begin
            desc_vld = 1'b0;
        end else if (desc_rd) begin
            desc_src_end = dsc_src[desc_alt];
            desc_dst_end = dsc_dst[desc_alt];
            desc_ctrl    = dsc_ctl[desc_alt];
            desc_vld     = 1'b1;
        end
        grant = arb_req && ($urandom % 2 == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MSZ; i++) begin
            mem[i]     = 8'($urandom);
            ref_mem[i] = mem[i];
        end
    endtask

    task automatic model(input logic [31:0] se, input logic [31:0] de, input logic [31:0] c);
        int n = int'(c[13:4]) + 1;
        for (int i = 0; i < n; i++) begin
            int r = n - 1 - i;
            int sa = int'(se) - r * step_bytes(c[27:26]);
            int da = int'(de) - r * step_bytes(c[31:30]);
            logic [31:0] v = '0;
            for (int b = 0; b < width_bytes(c[25:24]); b++) v[8*b +: 8] = ref_mem[(sa + b) % MSZ];
            for (int b = 0; b < width_bytes(c[29:28]); b++) ref_mem[(da + b) % MSZ] = v[8*b +: 8];
        end
    endtask

    task automatic cmp_mem(input string tag);
        int miss = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] != ref_mem[i]) miss++;
        check(tag, miss, 0);
    endtask

    task automatic pulse_req();
        req = 1'b1;
        tick();
        req = 1'b0;
    endtask

    task automatic wait_done(input string tag, input int k, input int maxc);
        int got = 0;
        for (int c = 0; c < maxc; c++) begin
            tick();
            if (done) got++;
            if (got >= k) begin
                req = 1'b0;
                break;
            end
        end
        req = 1'b0;
        check(tag, got, k);
    endtask

    function automatic logic [31:0] stopped(input logic [31:0] c);
        return {c[31:14], 10'd0, c[3], 3'b000};
    endfunction

    task automatic run_one(input string tag, input logic [31:0] se, input logic [31:0] de,
                           input logic [1:0] sst, input logic [1:0] sw,
                           input logic [1:0] dst, input logic [1:0] dw,
                           input logic [3:0] rp, input int n, input logic [2:0] mode);
        logic [31:0] c = mk_ctl(dst, dw, sst, sw, rp, 10'(n - 1), mode);
        int w0, a0, d0;
        dsc_src[0] = se; dsc_dst[0] = de; dsc_ctl[0] = c;
        fill_mem();
        model(se, de, c);
        w0 = n_wr; a0 = n_arb; d0 = n_done;
        if (mode == 3'b001) req = 1'b1;
        else pulse_req();
        wait_done({tag, " R11 done seen"}, 1, 60000);
        idle(6);
        cmp_mem({tag, " R1 R2 R3 data"});
        check({tag, " R4 beats"}, n_wr - w0, n);
        check({tag, " R11 done pulses"}, n_done - d0, 1);
        check({tag, " R10 final word"}, dsc_ctl[0], stopped(c));
        check({tag, " R7 R8 arbitrations"}, n_arb - a0, arbs_for(n, rp));
    endtask

    initial begin
        int w0, a0, d0;
        logic [31:0] c, cp, ca;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            dsc_src[i] = '0; dsc_dst[i] = '0; dsc_ctl[i] = '0;
        end
        for (int i = 0; i < MSZ; i++) begin
            mem[i] = '0; ref_mem[i] = '0;
        end
        idle(3);
        rst = 1'b0;
        tick();
        check("R13 reset mem_req", mem_req, 0);
        check("R12 reset arb_req", arb_req, 0);
        check("R11 reset done", done, 0);
        check("R10 reset wb_valid", wb_valid, 0);

        // word copy, auto, release every 8
        run_one("word auto", 32'h0F00, 32'h1F00, 2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 20, 3'b010);
        // byte source to fixed destination (R2)
        run_one("fixed dst", 32'h0F00, 32'h1F00, 2'b00, 2'b00, 2'b11, 2'b00, 4'd0, 6, 3'b010);
        // halfword source widened to word destination (R1)
        run_one("half to word", 32'h0F00, 32'h1F00, 2'b01, 2'b01, 2'b10, 2'b10, 4'd1, 9, 3'b001);
        // single item, basic (R4)
        run_one("single", 32'h0F00, 32'h1F00, 2'b10, 2'b10, 2'b10, 2'b10, 4'd0, 1, 3'b001);
        // full 1024-item cycle with saturated release code (R4 R8)
        run_one("max count", 32'h0FFC, 32'h1FFC, 2'b10, 2'b10, 2'b10, 2'b10, 4'd15, 1024, 3'b010);
        // release code 11 equals 1024 (R8)
        run_one("code 11", 32'h0F00, 32'h1F00, 2'b00, 2'b00, 2'b00, 2'b00, 4'd11, 40, 3'b010);

        // basic mode stalls without a fresh request (R6)
        c = mk_ctl(2'b10, 2'b10, 2'b10, 2'b10, 4'd2, 10'd9, 3'b001);
        dsc_src[0] = 32'h0F00; dsc_dst[0] = 32'h1F00; dsc_ctl[0] = c;
        fill_mem();
        model(32'h0F00, 32'h1F00, c);
        w0 = n_wr; d0 = n_done;
        pulse_req();
        idle(300);
        check("R6 stall beats", n_wr - w0, 4);
        check("R10 count after stall", dsc_ctl[0][13:4], 5);
        check("R6 mode kept", dsc_ctl[0][2:0], 1);
        check("R6 no done while stalled", n_done - d0, 0);
        pulse_req();
        idle(300);
        check("R6 second burst", n_wr - w0, 8);
        check("R10 count second", dsc_ctl[0][13:4], 1);
        pulse_req();
        wait_done("R6 completes", 1, 2000);
        idle(6);
        cmp_mem("R6 data");
        check("R10 stall final word", dsc_ctl[0], stopped(c));

        // stop and unsupported modes (R5)
        for (int m = 0; m < 2; m++) begin
            c = mk_ctl(2'b10, 2'b10, 2'b10, 2'b10, 4'd15, 10'd4, (m == 0) ? 3'b000 : 3'b101);
            dsc_ctl[0] = c;
            w0 = n_wr; a0 = n_arb; d0 = n_done;
            pulse_req();
            idle(100);
            check("R5 no beats", n_wr - w0, 0);
            check("R5 no done", n_done - d0, 0);
            check("R5 word untouched", dsc_ctl[0], c);
            check("R5 one arbitration", n_arb - a0, 1);
        end

        // disabled channel ignores request (R12)
        dsc_ctl[0] = mk_ctl(2'b10, 2'b10, 2'b10, 2'b10, 4'd15, 10'd4, 3'b010);
        chan_en = 1'b0;
        w0 = n_wr; a0 = n_arb;
        pulse_req();
        idle(100);
        check("R12 no arbitration", n_arb - a0, 0);
        check("R12 no beats", n_wr - w0, 0);
        chan_en = 1'b1;
        idle(20);
        check("R12 no late start", n_arb - a0, 0);

        // ping-pong (R9)
        cp = mk_ctl(2'b10, 2'b10, 2'b10, 2'b10, 4'd15, 10'd4, 3'b011);
        ca = mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 4'd15, 10'd6, 3'b011);
        dsc_src[0] = 32'h0400; dsc_dst[0] = 32'h1400; dsc_ctl[0] = cp;
        dsc_src[1] = 32'h0800; dsc_dst[1] = 32'h1800; dsc_ctl[1] = ca;
        fill_mem();
        model(32'h0400, 32'h1400, cp);
        model(32'h0800, 32'h1800, ca);
        w0 = n_wr; d0 = n_done;
        req = 1'b1;
        wait_done("R9 two completions", 2, 4000);
        idle(6);
        cmp_mem("R9 data both");
        check("R9 beats", n_wr - w0, 12);
        check("R9 primary stopped", dsc_ctl[0], stopped(cp));
        check("R9 alternate stopped", dsc_ctl[1], stopped(ca));
        check("R9 selection back to primary", desc_alt, 0);

        // random mixes (R1 R2 R7)
        for (int t = 0; t < 12; t++) begin
            logic [1:0] sst = 2'($urandom % 4);
            logic [1:0] dst = 2'($urandom % 4);
            logic [1:0] sw  = 2'($urandom % 3);
            logic [1:0] dw  = 2'($urandom % 3);
            logic [3:0] rp  = 4'($urandom % 13);
            int         n   = 1 + int'($urandom % 40);
            logic [2:0] md  = ($urandom % 2 == 0) ? 3'b001 : 3'b010;
            run_one($sformatf("random %0d", t), 32'h0F00, 32'h1F00, sst, sw, dst, dw, rp, n, md);
        end

        summary_and_end();
    end

endmodule